// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns a bank of already-synchronised GPIO pin levels into interrupt status. Each pin can be set up as edge or level sensitive. A polarity bit picks which edge or which level counts. A separate per-pin bit makes an edge pin fire on both transitions, so software never has to flip the polarity after each event. All configuration arrives as vectors from a register bank outside this block.

Edge events are held in a per-pin flag until software clears them with a write-one-to-clear end-of-interrupt strobe. Level events are not held: they track the pin directly. A per-pin enable decides whether a pin reports at all. A per-pin mask hides a pin from the masked status vector and from the interrupt line, but it leaves the raw status vector unchanged. The single interrupt output is the OR of the masked status.

Top module: `pin_irq_detect`

## Requirements
- R1: While reset is held, and after it is released, raw status, masked status and the interrupt are 0. The clock edge that ends reset only records pin levels, so a pin that is already high at that edge never counts as a transition.
- R2: With edge_sel=1 and both=0, polarity 1 detects a 0→1 pin change and polarity 0 detects a 1→0 change. The raw bit sets at the first clock edge that samples the new level, and it stays set after the pin returns.
- R3: With edge_sel=0, the raw bit equals 1 exactly when the pin level equals the polarity bit (1 = active high, 0 = active low). It follows the pin in the same cycle and is never latched.
- R4: With edge_sel=1 and both=1, either pin transition sets the raw bit, whatever the polarity bit holds.
- R5: A pin whose enable is 0 shows raw status 0, and any edge flag it held is dropped. The flag is also dropped when the pin is switched to level mode.
- R6: masked status = raw status AND NOT mask. The mask never changes raw status.
- R7: An end-of-interrupt bit of 1 clears that pin's held edge flag at the next clock edge. It has no effect on a pin in level mode.
- R8: If a qualifying edge is sampled at the same clock edge as that pin's end-of-interrupt bit, the flag stays set.
- R9: The interrupt output is 1 exactly when any masked status bit is 1, in the same cycle (default configuration, IRQ_REG=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | NPIN | Synchronised pin levels |
| irq_en | input | NPIN | Per-pin report enable |
| irq_mask | input | NPIN | Per-pin mask (1 = hidden) |
| edge_sel | input | NPIN | 1 = edge sensitive, 0 = level sensitive |
| trig_pol | input | NPIN | Rising/high when 1, falling/low when 0 |
| trig_both | input | NPIN | Both-edge detection for edge pins |
| eoi | input | NPIN | Write-one-to-clear strobe for edge flags |
| raw_stat | output | NPIN | Unmasked status |
| mask_stat | output | NPIN | Status after the mask |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check, on every cycle, that a disabled pin stays silent, that an inactive level pin reports nothing, that the mask never lets a hidden pin through, that an end-of-interrupt clears a flag unless a new edge arrives with it, and that the interrupt is never high without a masked bit. Whether the right edge is picked for a given polarity and both-edge setting, whether the flag survives the pin returning to its old level, and whether reset release avoids a false edge can only be shown by the bench. It does so with directed sequences and a long random run compared against a reference model.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
   localparam int unsigned MAX_PINS = 64;

   // Edge qualifier for one pin given the previous and current level
   function automatic logic edge_match(input logic prev, input logic cur,
                                       input logic pol, input logic both);
      logic rise, fall;
      rise = cur & ~prev;
      fall = ~cur & prev;
      return both ? (rise | fall) : (pol ? rise : fall);
   endfunction
endpackage

// File: rtl/pin_irq_cell.sv
module pin_irq_cell
   import pin_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic lvl,
   input  logic en,
   input  logic edge_sel,
   input  logic pol,
   input  logic both,
   input  logic eoi,
   output logic raw
);
   logic prev_q;
   logic flag_q;
   logic hit;

   assign hit = armed & en & edge_sel & edge_match(prev_q, lvl, pol, both);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= lvl;
         if (!en || !edge_sel)
            flag_q <= 1'b0;
         else if (hit)
            flag_q <= 1'b1;
         else if (eoi)
            flag_q <= 1'b0;
      end
   end

   always_comb begin
      if (!en)
         raw = 1'b0;
      else if (edge_sel)
         raw = flag_q;
      else
         raw = (lvl == pol);
   end

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !raw); // R5
   AST_LEVEL_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !edge_sel && (lvl != pol)) |-> !raw); // R3
   AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !hit) |=> !flag_q); // R7
   AST_NEW_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && eoi && $stable(en) && $stable(edge_sel)) |=> (flag_q || !en || !edge_sel)); // R8
endmodule

// File: rtl/pin_irq_merge.sv
module pin_irq_merge #(
   parameter int unsigned NPIN    = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] raw,
   input  logic [NPIN-1:0] mask,
   output logic [NPIN-1:0] masked,
   output logic            irq
);
   logic any_set;

   assign masked  = raw & ~mask;
   assign any_set = |masked;

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_set;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = any_set;
      end
   endgenerate

   AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
      (masked & mask) == '0); // R6
   AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !IRQ_REG) |-> (masked != '0)); // R9
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
   import pin_irq_pkg::*;
#(
   parameter int unsigned NPIN    = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pin_lvl,
   input  logic [NPIN-1:0] irq_en,
   input  logic [NPIN-1:0] irq_mask,
   input  logic [NPIN-1:0] edge_sel,
   input  logic [NPIN-1:0] trig_pol,
   input  logic [NPIN-1:0] trig_both,
   input  logic [NPIN-1:0] eoi,
   output logic [NPIN-1:0] raw_stat,
   output logic [NPIN-1:0] mask_stat,
   output logic            irq
);
   generate
      if (NPIN < 1 || NPIN > MAX_PINS) begin : g_bad_npin
         $error("pin_irq_detect: NPIN out of range");
      end
   endgenerate

   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   generate
      for (genvar i = 0; i < NPIN; i++) begin : g_pin
         pin_irq_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .armed    (armed_q),
            .lvl      (pin_lvl[i]),
            .en       (irq_en[i]),
            .edge_sel (edge_sel[i]),
            .pol      (trig_pol[i]),
            .both     (trig_both[i]),
            .eoi      (eoi[i]),
            .raw      (raw_stat[i])
         );
      end
   endgenerate

   pin_irq_merge #(.NPIN(NPIN), .IRQ_REG(IRQ_REG)) u_merge (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (raw_stat),
      .mask   (irq_mask),
      .masked (mask_stat),
      .irq    (irq)
   );

   AST_NO_FIRST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |=> ((raw_stat & edge_sel & irq_en) == '0 || !$stable(edge_sel) || !$stable(irq_en))); // R1
endmodule

// File: tb/pin_irq_detect_bench.sv
module pin_irq_detect_bench;
   localparam int N = 32;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] pin_lvl = '0, irq_en = '0, irq_mask = '0, edge_sel = '0;
   logic [N-1:0] trig_pol = '0, trig_both = '0, eoi = '0;
   logic [N-1:0] raw_stat, mask_stat;
   logic irq;

   int checks = 0;
   int errors = 0;
   logic [N-1:0] m_prev = '0, m_flag = '0;
   logic m_armed = 1'b0;

   always #10 clk = ~clk;

   pin_irq_detect #(.NPIN(N)) u_pin_irq_detect (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .irq_en(irq_en),
      .irq_mask(irq_mask), .edge_sel(edge_sel), .trig_pol(trig_pol),
      .trig_both(trig_both), .eoi(eoi), .raw_stat(raw_stat),
      .mask_stat(mask_stat), .irq(irq));

   function automatic logic [N-1:0] hits(input logic [N-1:0] prev, input logic [N-1:0] cur);
      logic [N-1:0] rise, fall;
      rise = cur & ~prev;
      fall = ~cur & prev;
      return (trig_both & (rise | fall)) | (~trig_both & trig_pol & rise) |
             (~trig_both & ~trig_pol & fall);
   endfunction

   function automatic logic [N-1:0] exp_raw();
      return irq_en & ((edge_sel & m_flag) | (~edge_sel & ~(pin_lvl ^ trig_pol)));
   endfunction

   task automatic step();
      logic [N-1:0] h;
      @(posedge clk);
      if (rst_n) begin
         h = {N{m_armed}} & irq_en & edge_sel & hits(m_prev, pin_lvl);
         m_flag = irq_en & edge_sel & (h | (m_flag & ~eoi));
         m_prev = pin_lvl;
         m_armed = 1'b1;
      end
      @(negedge clk);
   endtask

   task automatic check(input string tag);
      logic [N-1:0] er, em;
      er = exp_raw();
      em = er & ~irq_mask;
      checks++;
      if (raw_stat !== er) begin
         errors++;
         $display("FAIL %s raw_stat actual %h expected %h", tag, raw_stat, er);
      end
      checks++;
      if (mask_stat !== em) begin
         errors++;
         $display("FAIL %s mask_stat actual %h expected %h", tag, mask_stat, em);
      end
      checks++;
      if (irq !== (|em)) begin
         errors++;
         $display("FAIL %s irq actual %b expected %b", tag, irq, |em);
      end
   endtask

   task automatic expect_bit(input string tag, input int i, input logic v);
      checks++;
      if (raw_stat[i] !== v) begin
         errors++;
         $display("FAIL %s raw_stat[%0d] actual %b expected %b", tag, i, raw_stat[i], v);
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      // R1: reset state
      pin_lvl = '1; irq_en = '1; edge_sel = '1; trig_pol = '1;
      repeat (3) @(negedge clk);
      check("R1_reset");
      rst_n = 1'b1;
      step(); check("R1_release");
      step(); check("R1_settled");
      expect_bit("R1_no_edge", 3, 1'b0);

      // R2 rising on pin 0, falling on pin 1
      pin_lvl = '0; trig_pol = 32'h1; edge_sel = '1; irq_en = 32'h3;
      step(); check("R2_setup");
      expect_bit("R2_fall_pin1", 1, 1'b1);
      eoi = '1; step(); eoi = '0; check("R2_cleared");
      pin_lvl[0] = 1'b1; step(); expect_bit("R2_rise_pin0", 0, 1'b1); check("R2");
      pin_lvl[0] = 1'b0; step(); expect_bit("R2_held", 0, 1'b1); check("R2_held");

      // R3 level pins 2 (active high) and 5 (active low)
      irq_en = 32'h24; edge_sel = '0; trig_pol = 32'h4; pin_lvl = '0;
      step(); expect_bit("R3_low_idle", 2, 1'b0); expect_bit("R3_actlow", 5, 1'b1);
      pin_lvl = 32'h24; #1; expect_bit("R3_same_cycle", 2, 1'b1); expect_bit("R3_actlow_off", 5, 1'b0);
      eoi = 32'h24; step(); eoi = '0; expect_bit("R7_level_eoi", 2, 1'b1);
      pin_lvl = '0; #1; expect_bit("R3_not_held", 2, 1'b0); check("R3");

      // R4 both-edge on pin 4 with polarity 0
      irq_en = 32'h10; edge_sel = 32'h10; trig_both = 32'h10; trig_pol = '0;
      step(); step(); check("R4_idle");
      pin_lvl[4] = 1'b1; step(); expect_bit("R4_rise", 4, 1'b1);
      eoi[4] = 1'b1; step(); eoi = '0; expect_bit("R7_eoi", 4, 1'b0);
      pin_lvl[4] = 1'b0; step(); expect_bit("R4_fall", 4, 1'b1); check("R4");

      // R6 mask
      irq_mask = 32'h10; #1; check("R6_mask");
      expect_bit("R6_raw_kept", 4, 1'b1);
      irq_mask = '0;

      // R8 new edge with eoi on the same cycle
      pin_lvl[4] = 1'b1; eoi[4] = 1'b1; step(); eoi = '0;
      expect_bit("R8_edge_wins", 4, 1'b1); check("R8");

      // R5 disable drops flag
      irq_en = '0; #1; expect_bit("R5_off", 4, 1'b0);
      step(); irq_en = 32'h10; #1; expect_bit("R5_flag_dropped", 4, 1'b0); check("R5");
      step(); trig_both = '0;

      // R9 irq with mixed mask
      irq_en = '1; edge_sel = '0; trig_pol = '1; pin_lvl = 32'h0000_0100; irq_mask = 32'hFFFF_FEFF;
      #1; check("R9_one"); irq_mask = '1; #1; check("R9_none");

      // random run against the model
      for (int k = 0; k < 3000; k++) begin
         if ((k % 50) == 0) begin
            irq_en = $urandom; edge_sel = $urandom; trig_pol = $urandom;
            trig_both = $urandom; irq_mask = $urandom;
         end
         pin_lvl = pin_lvl ^ ($urandom & $urandom);
         eoi = $urandom & $urandom;
         step();
         check("RND");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule